// File: doc/BRIEF.md
# Segmented Accumulator CPU Sequencer

This block is the fetch, decode and address-generation core of a small 4-bit accumulator machine. It fetches one 8-bit instruction per clock from a separate instruction memory, decodes it and executes it in that same cycle. It holds the instruction pointer, four 4-bit data registers and the control registers that build addresses. The upper nibble of each instruction is the operation. The lower nibble is a literal, a register index or an ALU command.

No register in the block is wider than a nibble except the instruction pointer. An 8-bit data address is made by joining the data segment register (upper nibble) and the offset register (lower nibble). An 8-bit jump target is made by joining the jump segment register (upper nibble) and the instruction literal (lower nibble). Loads and stores always move data through the accumulator, so memory-mapped I/O uses the same path.

The ALU itself lies outside the block. The sequencer presents the accumulator and register B, a command nibble and a go strobe. It takes back a result and four flags. The data memory has a one-cycle write strobe and returns read data one clock after the read strobe. The loaded value is forwarded, so the very next instruction already sees it in the accumulator.

Top module: `seg_acc_seq`

## Requirements
- R1: While reset is high, no memory or ALU strobe is asserted. After reset, the instruction pointer is 0, the data address is 0 and all data registers read as 0.
- R2: After every non-jump, non-halt instruction the instruction pointer advances by one, wrapping from 255 to 0.
- R3: Opcode 1 loads the literal into A. Opcode 2 copies A into the register selected by literal bits [1:0] (0=A, 1=B, 2=C, 3=D). Opcode 3 copies that register into A.
- R4: Opcode 5 sets the data segment from the literal and opcode 6 sets the offset from the literal. The data address output is always {segment, offset}.
- R5: Opcode 8 asserts the write strobe for exactly its own cycle, with A on the write data and {segment, offset} on the address. At most one of write, read and ALU strobes is high in any cycle.
- R6: Opcode 7 asserts the read strobe. The data returned on the next clock becomes A and is already visible to the instruction that follows.
- R7: Opcode 9 asserts the ALU strobe with the literal as command, A and B as operands. The result is written to A and the flags {overflow, greater, less, zero} (bits 3..0) are latched.
- R8: Opcode 4 sets the jump segment. Opcode A loads the instruction pointer with {jump segment, literal}.
- R9: Opcodes B, C, D and E jump as opcode A when the latched zero, greater, less or overflow flag is set, and advance by one otherwise.
- R10: Opcode F freezes the instruction pointer and suppresses all strobes until reset. Reset then restarts at address 0.
- R11: Opcode 0 changes no register and asserts no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | 8 | Instruction pointer, address of the instruction memory |
| imem_data | input | 8 | Instruction at imem_addr |
| dmem_addr | output | 8 | Data address {segment, offset} |
| dmem_we | output | 1 | Data write strobe |
| dmem_re | output | 1 | Data read strobe |
| dmem_wdata | output | 4 | Write data (accumulator) |
| dmem_rdata | input | 4 | Read data, valid one clock after dmem_re |
| alu_go | output | 1 | ALU operation strobe |
| alu_cmd | output | 4 | ALU command nibble |
| alu_x | output | 4 | First ALU operand (A) |
| alu_y | output | 4 | Second ALU operand (B) |
| alu_result | input | 4 | ALU result |
| alu_flags | input | 4 | ALU flags {overflow, greater, less, zero} |

## Verification
A corrupted instruction pointer or jump segment appears on imem_addr in the very next cycle, so the jump and wrap tests compare the address trace cycle by cycle. A wrong data register, a lost load forward or a bad flag stays hidden until a store or a conditional jump uses it. The tests therefore route every register through a store to a distinct address, or through a branch, within a few instructions of setting it. Segment and offset faults show directly on dmem_addr as soon as the setting instruction retires.

// File: rtl/seq_pkg.sv
package seq_pkg;

  typedef enum logic [3:0] {
    OP_NOP  = 4'h0, OP_LDI  = 4'h1, OP_PUT  = 4'h2, OP_GET  = 4'h3,
    OP_JSEG = 4'h4, OP_DSEG = 4'h5, OP_DOFS = 4'h6, OP_LD   = 4'h7,
    OP_ST   = 4'h8, OP_ALU  = 4'h9, OP_JMP  = 4'hA, OP_JZ   = 4'hB,
    OP_JGT  = 4'hC, OP_JLT  = 4'hD, OP_JOV  = 4'hE, OP_HALT = 4'hF
  } opcode_t;

  localparam int FLAG_ZERO = 0;
  localparam int FLAG_LT   = 1;
  localparam int FLAG_GT   = 2;
  localparam int FLAG_OVF  = 3;

  typedef enum logic [1:0] {
    ASRC_HOLD, ASRC_LIT, ASRC_REG, ASRC_ALU
  } asrc_t;

  typedef struct packed {
    asrc_t a_src;
    logic  r_we;
    logic  jseg_we;
    logic  dseg_we;
    logic  dofs_we;
    logic  mem_re;
    logic  mem_we;
    logic  alu_go;
    logic  take;
    logic  halt;
  } ctrl_t;

endpackage

// File: rtl/seq_decode.sv
module seq_decode
  import seq_pkg::*;
#(
  parameter int DW = 4
) (
  input  logic [2*DW-1:0] instr,
  input  logic [3:0]      flags,
  input  logic            en,
  output ctrl_t           ctrl
);

  opcode_t op;
  assign op = opcode_t'(instr[2*DW-1 -: 4]);

  always_comb begin
    ctrl = '0;
    ctrl.a_src = ASRC_HOLD;
    if (en) begin
      unique case (op)
        OP_NOP:  ;
        OP_LDI:  ctrl.a_src   = ASRC_LIT;
        OP_PUT:  ctrl.r_we    = 1'b1;
        OP_GET:  ctrl.a_src   = ASRC_REG;
        OP_JSEG: ctrl.jseg_we = 1'b1;
        OP_DSEG: ctrl.dseg_we = 1'b1;
        OP_DOFS: ctrl.dofs_we = 1'b1;
        OP_LD:   ctrl.mem_re  = 1'b1;
        OP_ST:   ctrl.mem_we  = 1'b1;
        OP_ALU: begin
          ctrl.alu_go = 1'b1;
          ctrl.a_src  = ASRC_ALU;
        end
        OP_JMP:  ctrl.take = 1'b1;
        OP_JZ:   ctrl.take = flags[FLAG_ZERO];
        OP_JGT:  ctrl.take = flags[FLAG_GT];
        OP_JLT:  ctrl.take = flags[FLAG_LT];
        OP_JOV:  ctrl.take = flags[FLAG_OVF];
        OP_HALT: ctrl.halt = 1'b1;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/seq_regfile.sv
module seq_regfile #(
  parameter int DW    = 4,
  parameter int NREGS = 4,
  localparam int RIW  = $clog2(NREGS)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           a_we,
  input  logic [DW-1:0]  a_val,
  input  logic           n_we,
  input  logic [RIW-1:0] sel,
  input  logic           ld_pend,
  input  logic [DW-1:0]  ld_data,
  output logic [DW-1:0]  a_eff,
  output logic [DW-1:0]  b_val,
  output logic [DW-1:0]  sel_val
);

  logic [DW-1:0] regs [NREGS];

  // A pending load result overrides the stored accumulator for one cycle
  assign a_eff = ld_pend ? ld_data : regs[0];

  for (genvar g = 0; g < NREGS; g++) begin : g_reg
    if (g == 0) begin : g_acc
      always_ff @(posedge clk) begin
        if (rst)       regs[g] <= '0;
        else if (a_we) regs[g] <= a_val;
        else           regs[g] <= a_eff;
      end
    end else begin : g_gen
      always_ff @(posedge clk) begin
        if (rst)                            regs[g] <= '0;
        else if (n_we && sel == RIW'(g))    regs[g] <= a_eff;
      end
    end
  end

  assign b_val   = regs[1];
  assign sel_val = (sel == '0) ? a_eff : regs[sel];

endmodule

// File: rtl/seq_ctlregs.sv
module seq_ctlregs #(
  parameter int DW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          jseg_we,
  input  logic          dseg_we,
  input  logic          dofs_we,
  input  logic          flags_we,
  input  logic [DW-1:0] lit,
  input  logic [3:0]    alu_flags,
  output logic [DW-1:0] jseg,
  output logic [DW-1:0] dseg,
  output logic [DW-1:0] dofs,
  output logic [3:0]    flags
);

  always_ff @(posedge clk) begin
    if (rst) begin
      jseg  <= '0;
      dseg  <= '0;
      dofs  <= '0;
      flags <= '0;
    end else begin
      if (jseg_we)  jseg  <= lit;
      if (dseg_we)  dseg  <= lit;
      if (dofs_we)  dofs  <= lit;
      if (flags_we) flags <= alu_flags;
    end
  end

endmodule

// File: rtl/seq_ptr.sv
module seq_ptr #(
  parameter int DW = 4,
  localparam int AW = 2 * DW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          halt,
  input  logic          take,
  input  logic [DW-1:0] jseg,
  input  logic [DW-1:0] lit,
  output logic [AW-1:0] ip,
  output logic          halted
);

  always_ff @(posedge clk) begin
    if (rst) begin
      ip     <= '0;
      halted <= 1'b0;
    end else if (!halted) begin
      if (halt)      halted <= 1'b1;
      else if (take) ip     <= {jseg, lit};
      else           ip     <= ip + AW'(1);
    end
  end

endmodule

// File: rtl/seg_acc_seq.sv
module seg_acc_seq
  import seq_pkg::*;
#(
  parameter int DW    = 4,
  parameter int NREGS = 4,
  localparam int AW   = 2 * DW,
  localparam int RIW  = $clog2(NREGS)
) (
  input  logic          clk,
  input  logic          rst,
  output logic [AW-1:0] imem_addr,
  input  logic [AW-1:0] imem_data,
  output logic [AW-1:0] dmem_addr,
  output logic          dmem_we,
  output logic          dmem_re,
  output logic [DW-1:0] dmem_wdata,
  input  logic [DW-1:0] dmem_rdata,
  output logic          alu_go,
  output logic [3:0]    alu_cmd,
  output logic [DW-1:0] alu_x,
  output logic [DW-1:0] alu_y,
  input  logic [DW-1:0] alu_result,
  input  logic [3:0]    alu_flags
);

  ctrl_t         ctrl;
  logic          halted;
  logic          ld_pend;
  logic [DW-1:0] lit;
  logic [DW-1:0] jseg, dseg, dofs;
  logic [3:0]    flags;
  logic [DW-1:0] a_eff, b_val, sel_val, a_val;

  assign lit = imem_data[DW-1:0];

  seq_decode #(.DW(DW)) u_dec (
    .instr (imem_data),
    .flags (flags),
    .en    (!halted && !rst),
    .ctrl  (ctrl)
  );

  seq_ctlregs #(.DW(DW)) u_ctl (
    .clk       (clk),
    .rst       (rst),
    .jseg_we   (ctrl.jseg_we),
    .dseg_we   (ctrl.dseg_we),
    .dofs_we   (ctrl.dofs_we),
    .flags_we  (ctrl.alu_go),
    .lit       (lit),
    .alu_flags (alu_flags),
    .jseg      (jseg),
    .dseg      (dseg),
    .dofs      (dofs),
    .flags     (flags)
  );

  always_comb begin
    unique case (ctrl.a_src)
      ASRC_LIT: a_val = lit;
      ASRC_REG: a_val = sel_val;
      ASRC_ALU: a_val = alu_result;
      default:  a_val = a_eff;
    endcase
  end

  seq_regfile #(.DW(DW), .NREGS(NREGS)) u_rf (
    .clk     (clk),
    .rst     (rst),
    .a_we    (ctrl.a_src != ASRC_HOLD),
    .a_val   (a_val),
    .n_we    (ctrl.r_we),
    .sel     (lit[RIW-1:0]),
    .ld_pend (ld_pend),
    .ld_data (dmem_rdata),
    .a_eff   (a_eff),
    .b_val   (b_val),
    .sel_val (sel_val)
  );

  seq_ptr #(.DW(DW)) u_ptr (
    .clk    (clk),
    .rst    (rst),
    .halt   (ctrl.halt),
    .take   (ctrl.take),
    .jseg   (jseg),
    .lit    (lit),
    .ip     (imem_addr),
    .halted (halted)
  );

  always_ff @(posedge clk) begin
    if (rst) ld_pend <= 1'b0;
    else     ld_pend <= ctrl.mem_re;
  end

  assign dmem_addr  = {dseg, dofs};
  assign dmem_we    = ctrl.mem_we;
  assign dmem_re    = ctrl.mem_re;
  assign dmem_wdata = a_eff;
  assign alu_go     = ctrl.alu_go;
  assign alu_cmd    = imem_data[3:0];
  assign alu_x      = a_eff;
  assign alu_y      = b_val;

endmodule

// File: rtl/seq_chk.sv
module seq_chk #(
  parameter int DW = 4,
  localparam int AW = 2 * DW
) (
  input logic          clk,
  input logic          rst,
  input logic          halted,
  input logic [DW-1:0] jseg,
  input logic [AW-1:0] imem_addr,
  input logic [AW-1:0] imem_data,
  input logic          dmem_we,
  input logic          dmem_re,
  input logic          alu_go
);

  logic rst_q;
  always_ff @(posedge clk) begin
    rst_q <= rst;
    // R1
    if (rst_q && !rst) begin
      reset_ip_chk: assert (imem_addr == '0 && !halted)
        else $error("ip not cleared by reset");
    end
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |-> !dmem_we && !dmem_re && !alu_go);

  // R2
  step_chk: assert property (@(posedge clk) disable iff (rst)
    (!halted && imem_data[AW-1 -: 4] < 4'hA) |=> imem_addr == $past(imem_addr) + AW'(1));

  // R8
  jump_target_chk: assert property (@(posedge clk) disable iff (rst)
    (!halted && imem_data[AW-1 -: 4] == 4'hA)
      |=> imem_addr == {$past(jseg), $past(imem_data[DW-1:0])});

  // R10
  halt_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    halted |=> $stable(imem_addr));

  // R10
  halt_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    halted |-> !dmem_we && !dmem_re && !alu_go);

  // R5
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({dmem_we, dmem_re, alu_go}));

endmodule

bind seg_acc_seq seq_chk #(.DW(DW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .halted    (halted),
  .jseg      (jseg),
  .imem_addr (imem_addr),
  .imem_data (imem_data),
  .dmem_we   (dmem_we),
  .dmem_re   (dmem_re),
  .alu_go    (alu_go)
);

// File: tb/sim_seg_acc_seq.sv
module sim_seg_acc_seq;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] imem_addr, imem_data, dmem_addr;
  logic       dmem_we, dmem_re, alu_go;
  logic [3:0] dmem_wdata, dmem_rdata, alu_cmd, alu_x, alu_y, alu_result, alu_flags;

  logic [7:0] imem [256];
  logic [3:0] dmem [256];
  int n_chk = 0, n_bad = 0, we_cnt = 0, cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  seg_acc_seq u0 (
    .clk(clk), .rst(rst), .imem_addr(imem_addr), .imem_data(imem_data),
    .dmem_addr(dmem_addr), .dmem_we(dmem_we), .dmem_re(dmem_re),
    .dmem_wdata(dmem_wdata), .dmem_rdata(dmem_rdata), .alu_go(alu_go),
    .alu_cmd(alu_cmd), .alu_x(alu_x), .alu_y(alu_y),
    .alu_result(alu_result), .alu_flags(alu_flags)
  );

  assign imem_data = imem[imem_addr];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (dmem_we) begin
      dmem[dmem_addr] <= dmem_wdata;
      we_cnt <= we_cnt + 1;
    end
    if (dmem_re) dmem_rdata <= dmem[dmem_addr];
  end

  // ALU model: 0 add, 1 compare, 2 not, 3 and, 4 or, 5 xor; flags {ovf,gt,lt,zero}
  always_comb begin
    logic [4:0] sum;
    sum = {1'b0, alu_x} + {1'b0, alu_y};
    alu_flags = '0;
    case (alu_cmd)
      4'h0: begin alu_result = sum[3:0]; alu_flags[3] = sum[4]; end
      4'h1: begin alu_result = alu_x; alu_flags[2] = alu_x > alu_y; alu_flags[1] = alu_x < alu_y; end
      4'h2: alu_result = ~alu_x;
      4'h3: alu_result = alu_x & alu_y;
      4'h4: alu_result = alu_x | alu_y;
      default: alu_result = alu_x ^ alu_y;
    endcase
    if (alu_cmd == 4'h1) alu_flags[0] = alu_x == alu_y;
    else                 alu_flags[0] = alu_result == 4'h0;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 256; i++) begin
      imem[i] = 8'h00;
      dmem[i] = 4'h0;
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    chk("R1 strobes in reset", {dmem_we, dmem_re, alu_go}, 3'b000);
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    clear_mem();
    dmem[0] = 4'hF; dmem[1] = 4'hF;
    imem[0] = 8'h80; imem[1] = 8'h31; imem[2] = 8'h61; imem[3] = 8'h80; imem[4] = 8'hF0;
    do_reset();
    chk("R1 ip after reset", imem_addr, 8'h00);
    chk("R1 daddr after reset", dmem_addr, 8'h00);
    run(10);
    chk("R1 A zero", dmem[0], 4'h0);
    chk("R1 B zero", dmem[1], 4'h0);
  endtask

  task automatic t_wrap();
    int w0;
    clear_mem();
    do_reset();
    w0 = we_cnt;
    run(255);
    chk("R2 ip at 255", imem_addr, 8'hFF);
    run(1);
    chk("R2 ip wraps", imem_addr, 8'h00);
    chk("R11 nop no store", we_cnt - w0, 0);
    chk("R11 nop daddr", dmem_addr, 8'h00);
  endtask

  task automatic t_moves();
    logic [7:0] p [17] = '{8'h15, 8'h21, 8'h19, 8'h22, 8'h1C, 8'h23, 8'h53, 8'h67,
                           8'h31, 8'h80, 8'h68, 8'h32, 8'h80, 8'h69, 8'h33, 8'h80, 8'hF0};
    int w0;
    clear_mem();
    foreach (p[i]) imem[i] = p[i];
    do_reset();
    w0 = we_cnt;
    run(8);
    chk("R4 daddr {seg,ofs}", dmem_addr, 8'h37);
    run(1);
    chk("R5 store strobe", dmem_we, 1'b1);
    chk("R5 store data", dmem_wdata, 4'h5);
    run(12);
    chk("R3 B via store", dmem[8'h37], 4'h5);
    chk("R3 C via store", dmem[8'h38], 4'h9);
    chk("R3 D via store", dmem[8'h39], 4'hC);
    chk("R5 store count", we_cnt - w0, 3);
  endtask

  task automatic t_load();
    logic [7:0] p [12] = '{8'h52, 8'h61, 8'h70, 8'h21, 8'h62, 8'h70,
                           8'h63, 8'h80, 8'h31, 8'h64, 8'h80, 8'hF0};
    clear_mem();
    foreach (p[i]) imem[i] = p[i];
    dmem[8'h21] = 4'h6; dmem[8'h22] = 4'hA;
    do_reset();
    run(2);
    chk("R6 read strobe", dmem_re, 1'b1);
    chk("R6 read addr", dmem_addr, 8'h21);
    run(1);
    chk("R6 forwarded to next", dmem_wdata, 4'h6);
    run(15);
    chk("R6 loaded value stored", dmem[8'h23], 4'hA);
    chk("R6 forward into B", dmem[8'h24], 4'h6);
  endtask

  task automatic t_alu();
    logic [7:0] p [14] = '{8'h15, 8'h21, 8'h13, 8'h90, 8'h54, 8'h60, 8'h80,
                           8'h95, 8'h61, 8'h80, 8'h92, 8'h62, 8'h80, 8'hF0};
    clear_mem();
    foreach (p[i]) imem[i] = p[i];
    do_reset();
    run(3);
    chk("R7 alu strobe", alu_go, 1'b1);
    chk("R7 alu cmd", alu_cmd, 4'h0);
    chk("R7 alu x=A", alu_x, 4'h3);
    chk("R7 alu y=B", alu_y, 4'h5);
    run(15);
    chk("R7 add result", dmem[8'h40], 4'h8);
    chk("R7 xor result", dmem[8'h41], 4'hD);
    chk("R7 not result", dmem[8'h42], 4'h2);
  endtask

  task automatic t_jumps();
    int w0;
    clear_mem();
    imem[0] = 8'h43; imem[1] = 8'h1F; imem[2] = 8'h21; imem[3] = 8'h11;
    imem[4] = 8'h90; imem[5] = 8'hE5;
    imem[8'h35] = 8'hB8; imem[8'h38] = 8'hC0; imem[8'h39] = 8'hD0;
    imem[8'h3A] = 8'h91; imem[8'h3B] = 8'hDE; imem[8'h3E] = 8'h47;
    imem[8'h3F] = 8'hA2; imem[8'h72] = 8'hF0;
    do_reset();
    run(6);  chk("R9 jump on overflow", imem_addr, 8'h35);
    run(1);  chk("R9 jump on zero", imem_addr, 8'h38);
    run(1);  chk("R9 greater not taken", imem_addr, 8'h39);
    run(1);  chk("R9 less not taken", imem_addr, 8'h3A);
    run(2);  chk("R9 jump on less", imem_addr, 8'h3E);
    run(2);  chk("R8 unconditional jump", imem_addr, 8'h72);
    w0 = we_cnt;
    run(20); chk("R10 halted ip frozen", imem_addr, 8'h72);
    chk("R10 no strobes", {dmem_we, dmem_re, alu_go}, 3'b000);
    chk("R10 no stores", we_cnt - w0, 0);
    do_reset();
    chk("R10 restart after reset", imem_addr, 8'h00);
  endtask

  initial begin
    t_reset();
    t_wrap();
    t_moves();
    t_load();
    t_alu();
    t_jumps();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    wait (cyc >= 20000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual %0d expected < 20000 cycles", cyc);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule